// File: doc/BRIEF.md
# Miller-Rabin Primality Round Sequencer

This block decides whether an odd candidate `N` is a probable prime by running a number of randomised strong-pseudoprime rounds. It does not do the modular arithmetic itself. Instead it commands an external modular-power unit over a small request/complete handshake. Each request carries a base, an exponent and the modulus, and the unit answers with `base^pow mod N`.

When the sequencer accepts a candidate, it first splits `N-1` into an odd part `D` and a power of two `2^S`. It does this by shifting right one place per cycle. For each round it then:
- draws a base from an internal LFSR and folds that base into `[2, N-2]`;
- asks for `A^D mod N`;
- classifies the answer as "equals 1", "equals N-1" or "other", and then either closes the round or asks for further squarings of the last answer.

A one-cycle `done` pulse reports the verdict. The `prime` bit then holds that verdict until the next accepted start.

Top module: `mr_prime_ctrl`

## Requirements
- R1: While reset is active and just after it, `done`, `prime`, `busy` and `exp_go` are all 0.
- R2: An even candidate, or one below 5, issues no power request. Its result is reported with `done` in the cycle after the start is taken. `prime` is 1 exactly for 2 and 3.
- R3: The opening request of each round has `exp_sq`=0, `exp_mod`=N, and `exp_pow`=D. D is the odd value that satisfies D·2^S = N-1.
- R4: Every opening request carries a base with 2 ≤ `exp_base` ≤ N-2.
- R5: If the opening result is 1 or N-1, the round passes. The next request is then a new round's opening request (`exp_sq`=0), or the run finishes.
- R6: A squaring request has `exp_sq`=1, `exp_pow`=2, and `exp_base` equal to the previous result. A round issues at most S-1 squarings, so none when S=1. A round that reaches that limit without a decisive result is composite.
- R7: After a squaring, a result of 1 ends the run as composite (`prime`=0). A result of N-1 passes the round.
- R8: `prime`=1 only if every round passed. A candidate that is truly prime always yields `prime`=1.
- R9: A round count of 0 is treated as one round.
- R10: `start` is ignored while `busy` is 1. The latched modulus and the verdict are not disturbed.
- R11: `exp_go` is high for exactly one cycle per request. No new request is issued before `exp_done` answers the previous one.
- R12: `done` is a one-cycle pulse. `prime` keeps its value after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Take a new candidate (honoured only when idle) |
| cand | input | W | Candidate N |
| rounds | input | KW | Number of rounds K (0 means 1) |
| exp_done | input | 1 | Power unit completion strobe |
| exp_res | input | W | Power unit result |
| exp_go | output | 1 | Power request strobe |
| exp_sq | output | 1 | 1 = squaring request, 0 = round opening |
| exp_base | output | W | Base of the request |
| exp_pow | output | W | Exponent of the request |
| exp_mod | output | W | Modulus (latched N) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Verdict strobe |
| prime | output | 1 | Verdict: probable prime |

## Verification
A completion from the power unit and a fresh `start` request can arrive in the same cycle. At that moment the sequencer is still busy with a round and must take the result while discarding the new candidate. The bench provokes this by raising `start`, with a different candidate value, on the exact cycle its power-unit model asserts `exp_done`. It then judges the run by whether the modulus on `exp_mod` still shows the original N and whether the verdict agrees with the round outcomes the model itself produced. Forced result sequences from the model also drive the round and squaring decisions through every branch, including S=1 and the squaring limit.

// File: rtl/mr_pkg.sv
package mr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_DRAW,
    ST_ISSUE,
    ST_WAIT,
    ST_JUDGE,
    ST_FIN
  } mr_state_e;

  // result classification codes
  localparam logic [1:0] CLS_OTHER = 2'b00;
  localparam logic [1:0] CLS_ONE   = 2'b01;
  localparam logic [1:0] CLS_NM1   = 2'b10;

endpackage

// File: rtl/mr_split.sv
// Parallel-load right shifter: strips trailing zeros of N-1, counting them.
module mr_split #(
  parameter int W  = 16,
  parameter int SW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic [W-1:0]  value,
  output logic [W-1:0]  odd_part,
  output logic [SW-1:0] twos,
  output logic          ready
);

  logic [W-1:0]  sh_q;
  logic [SW-1:0] cnt_q;
  logic          shift_en;

  assign shift_en = !load && (sh_q != '0) && !sh_q[0];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (load) begin
        sh_q  <= value;
        cnt_q <= '0;
      end else if (shift_en) begin
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q + SW'(1);
      end
    end
  end

  assign odd_part = sh_q;
  assign twos     = cnt_q;
  assign ready    = sh_q[0];

  // R3: once the odd part is reached it stays put until reloaded
  p_hold_odd_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (sh_q[0] && !load) |=> ($stable(sh_q) && $stable(cnt_q)));

endmodule

// File: rtl/mr_lfsr.sv
// Galois LFSR used as the base source.
module mr_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         step,
  output logic [W-1:0] value
);

  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  always_comb begin
    st_d = st_q[0] ? ((st_q >> 1) ^ TAPS) : (st_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SEED;
    end else if (step) begin
      st_q <= st_d;
    end
  end

  assign value = st_q;

  // R4: the generator never locks up in the all-zero state
  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    st_q != '0);

endmodule

// File: rtl/mr_base_fit.sv
// Folds a raw random word into [2, N-2] with one mask and one subtract.
module mr_base_fit #(
  parameter int W = 16
) (
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] raw,
  output logic [W-1:0] base
);

  logic [W-1:0] span;
  logic [W-1:0] mask;
  logic [W-1:0] cut;
  logic [W-1:0] folded;

  always_comb begin
    span = modulus - W'(4);
    mask = span;
    for (int i = 0; i < W; i++) begin
      mask = mask | (mask >> 1);
    end
    cut    = raw & mask;
    folded = (cut > span) ? (cut - span - W'(1)) : cut;
    base   = folded + W'(2);
  end

endmodule

// File: rtl/mr_classify.sv
// Two-bit status of a power result against 1 and N-1.
module mr_classify #(
  parameter int W = 16
) (
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] x,
  output logic [1:0]   status
);

  always_comb begin
    status = {x == (modulus - W'(1)), x == W'(1)};
  end

endmodule

// File: rtl/mr_prime_ctrl.sv
module mr_prime_ctrl
  import mr_pkg::*;
#(
  parameter int           W    = 16,
  parameter int           KW   = 4,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  cand,
  input  logic [KW-1:0] rounds,
  input  logic          exp_done,
  input  logic [W-1:0]  exp_res,
  output logic          exp_go,
  output logic          exp_sq,
  output logic [W-1:0]  exp_base,
  output logic [W-1:0]  exp_pow,
  output logic [W-1:0]  exp_mod,
  output logic          busy,
  output logic          done,
  output logic          prime
);

  localparam int SW = $clog2(W + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  mr_state_e     state_q, state_d;
  logic [W-1:0]  n_q, base_q, x_q;
  logic [KW-1:0] k_q, rnd_q, rnd_d;
  logic [SW-1:0] sqc_q, sqc_d;
  logic          sqph_q, sqph_d;
  logic          prime_q, prime_d;
  logic          n_en, k_en, base_en, x_en, ld_split, lfsr_step;

  logic [W-1:0]  d_val, rnd_word, fit_base;
  logic [SW-1:0] s_val;
  logic          split_ready;
  logic [1:0]    status;
  logic          cand_ok, cand_small_prime, last_round;

  mr_split #(.W(W), .SW(SW)) i_split (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (ld_split),
    .value    (cand - W'(1)),
    .odd_part (d_val),
    .twos     (s_val),
    .ready    (split_ready)
  );

  mr_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) i_lfsr (
    .clk    (clk),
    .rst_ni (rst_ni),
    .step   (lfsr_step),
    .value  (rnd_word)
  );

  mr_base_fit #(.W(W)) i_fit (
    .modulus (n_q),
    .raw     (rnd_word),
    .base    (fit_base)
  );

  mr_classify #(.W(W)) i_cls (
    .modulus (n_q),
    .x       (x_q),
    .status  (status)
  );

  assign cand_ok          = cand[0] && (cand >= W'(5));
  assign cand_small_prime = (cand == W'(2)) || (cand == W'(3));
  assign last_round       = ({1'b0, rnd_q} + (KW+1)'(1)) >= {1'b0, k_q};

  // next-state logic
  always_comb begin
    state_d   = state_q;
    rnd_d     = rnd_q;
    sqc_d     = sqc_q;
    sqph_d    = sqph_q;
    prime_d   = prime_q;
    n_en      = 1'b0;
    k_en      = 1'b0;
    base_en   = 1'b0;
    x_en      = 1'b0;
    ld_split  = 1'b0;
    lfsr_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          n_en    = 1'b1;
          k_en    = 1'b1;
          rnd_d   = '0;
          prime_d = 1'b0;
          if (cand_ok) begin
            ld_split = 1'b1;
            state_d  = ST_SPLIT;
          end else begin
            prime_d = cand_small_prime;
            state_d = ST_FIN;
          end
        end
      end
      ST_SPLIT: begin
        if (split_ready) state_d = ST_DRAW;
      end
      ST_DRAW: begin
        lfsr_step = 1'b1;
        base_en   = 1'b1;
        sqph_d    = 1'b0;
        sqc_d     = '0;
        state_d   = ST_ISSUE;
      end
      ST_ISSUE: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (exp_done) begin
          x_en    = 1'b1;
          if (sqph_q) sqc_d = sqc_q + SW'(1);
          state_d = ST_JUDGE;
        end
      end
      ST_JUDGE: begin
        if ((status == CLS_NM1) || ((status == CLS_ONE) && !sqph_q)) begin
          if (last_round) begin
            prime_d = 1'b1;
            state_d = ST_FIN;
          end else begin
            rnd_d   = rnd_q + KW'(1);
            state_d = ST_DRAW;
          end
        end else if ((status == CLS_ONE) || (sqc_q == (s_val - SW'(1)))) begin
          prime_d = 1'b0;
          state_d = ST_FIN;
        end else begin
          sqph_d  = 1'b1;
          state_d = ST_ISSUE;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      k_q     <= '0;
      rnd_q   <= '0;
      base_q  <= '0;
      x_q     <= '0;
      sqc_q   <= '0;
      sqph_q  <= 1'b0;
      prime_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rnd_q   <= rnd_d;
      sqc_q   <= sqc_d;
      sqph_q  <= sqph_d;
      prime_q <= prime_d;
      if (n_en)    n_q    <= cand;
      if (k_en)    k_q    <= (rounds == '0) ? KW'(1) : rounds;
      if (base_en) base_q <= fit_base;
      if (x_en)    x_q    <= exp_res;
    end
  end

  assign exp_go   = (state_q == ST_ISSUE);
  assign exp_sq   = sqph_q;
  assign exp_base = sqph_q ? x_q : base_q;
  assign exp_pow  = sqph_q ? W'(2) : d_val;
  assign exp_mod  = n_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign prime    = prime_q;

  // R11: request strobe lasts one cycle
  p_go_pulse_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    exp_go |=> !exp_go);

  // R12: verdict strobe lasts one cycle and the verdict holds after it
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> (!done && $stable(prime)));

  // R4: opening base inside [2, N-2]
  p_base_range_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (exp_go && !exp_sq) |-> ((exp_base >= W'(2)) && (exp_base <= n_q - W'(2))));

  // R3: opening exponent is odd and its shift restores N-1
  p_pow_odd_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (exp_go && !exp_sq) |-> (exp_pow[0] && ((exp_pow << s_val) == (n_q - W'(1)))));

  // R6: a squaring is only requested below the S-1 limit
  p_sq_limit_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (exp_go && exp_sq) |-> (sqc_q < (s_val - SW'(1))));

  // R10: a start during a run leaves the latched modulus alone
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && start) |=> $stable(exp_mod));

endmodule

// File: tb/test_mr_prime_ctrl.sv
module test_mr_prime_ctrl;

  localparam int W  = 16;
  localparam int KW = 4;
  localparam int VN = 18;

  // {candidate, rounds}
  localparam logic [W+KW-1:0] VEC [VN] = '{
    {16'd0, 4'd3},    {16'd1, 4'd3},    {16'd2, 4'd2},    {16'd3, 4'd5},
    {16'd4, 4'd2},    {16'd100, 4'd3},  {16'd5, 4'd3},    {16'd7, 4'd4},
    {16'd97, 4'd7},   {16'd7919, 4'd4}, {16'd65521, 4'd4},{16'd9, 4'd5},
    {16'd15, 4'd3},   {16'd561, 4'd4},  {16'd341, 4'd4},  {16'd25, 4'd2},
    {16'd13, 4'd0},   {16'd1105, 4'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  cand = '0;
  logic [KW-1:0] rounds = '0;
  logic          exp_done = 1'b0;
  logic [W-1:0]  exp_res = '0;
  logic          exp_go, exp_sq, busy, done, prime;
  logic [W-1:0]  exp_base, exp_pow, exp_mod;

  always #5 clk = ~clk;

  mr_prime_ctrl i_mr_prime_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cand(cand), .rounds(rounds),
    .exp_done(exp_done), .exp_res(exp_res), .exp_go(exp_go), .exp_sq(exp_sq),
    .exp_base(exp_base), .exp_pow(exp_pow), .exp_mod(exp_mod),
    .busy(busy), .done(done), .prime(prime)
  );

  int checks = 0;
  int fails  = 0;

  // power-unit model state
  int          cur_n, cur_d, cur_s;
  int          passed, openings, sq_in_round, reqs;
  bit          failed, pending;
  logic [W-1:0] last_res;
  logic [W-1:0] ovr [8];
  int          ovr_n = 0, ovr_i = 0;
  bit          poke = 1'b0;
  int          lat_sel = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int modpow(input int b, input int e, input int m);
    longint r = 1;
    longint x = b % m;
    int     k = e;
    while (k > 0) begin
      if (k[0]) r = (r * x) % m;
      x = (x * x) % m;
      k = k >> 1;
    end
    return int'(r);
  endfunction

  function automatic bit is_prime(input int n);
    if (n < 2) return 1'b0;
    for (int f = 2; f * f <= n; f++) if (n % f == 0) return 1'b0;
    return 1'b1;
  endfunction

  // behavioural power unit with its own round bookkeeping
  initial begin
    forever begin
      @(negedge clk);
      if (exp_go) begin
        int res;
        int lat;
        reqs++;
        chk(exp_mod == cur_n, "R3", "modulus", exp_mod, cur_n);
        if (exp_sq) begin
          chk(pending, "R6", "square only in undecided round", 0, 1);
          chk(exp_base == last_res && exp_pow == 2, "R6", "square operands",
              exp_base, last_res);
        end else begin
          chk(!pending, "R5", "opening after decided round", 1, 0);
          chk(exp_base >= 2 && exp_base <= cur_n - 2, "R4", "base range", exp_base, 2);
          chk(exp_pow == cur_d, "R3", "odd exponent", exp_pow, cur_d);
          sq_in_round = 0;
          openings++;
        end
        if (ovr_i < ovr_n) begin
          res = ovr[ovr_i];
          ovr_i++;
        end else begin
          res = modpow(exp_base, exp_pow, cur_n);
        end
        if (!exp_sq) begin
          if (res == 1 || res == cur_n - 1) passed++;
          else if (cur_s == 1) failed = 1'b1;
          else pending = 1'b1;
        end else begin
          sq_in_round++;
          chk(sq_in_round <= cur_s - 1, "R6", "square count", sq_in_round, cur_s - 1);
          if (res == cur_n - 1) begin passed++; pending = 1'b0; end
          else if (res == 1) begin failed = 1'b1; pending = 1'b0; end
          else if (sq_in_round >= cur_s - 1) begin failed = 1'b1; pending = 1'b0; end
        end
        lat = 1 + (lat_sel % 3);
        lat_sel++;
        @(negedge clk);
        chk(!exp_go, "R11", "request strobe width", exp_go, 0);
        repeat (lat - 1) @(negedge clk);
        exp_done = 1'b1;
        exp_res  = W'(res);
        last_res = W'(res);
        if (poke) begin
          start = 1'b1;
          cand  = 16'd4;
        end
        @(negedge clk);
        exp_done = 1'b0;
        if (poke) begin
          start = 1'b0;
          poke  = 1'b0;
        end
      end
    end
  end

  task automatic run(input int n, input int k, input bit math);
    int cyc;
    int keff;
    bit exp_p;
    bit held;
    cur_n = n; cur_d = n - 1; cur_s = 0;
    if (n >= 2) while (cur_d > 0 && cur_d % 2 == 0) begin cur_d /= 2; cur_s++; end
    passed = 0; openings = 0; reqs = 0; failed = 1'b0; pending = 1'b0;
    @(negedge clk);
    cand = W'(n); rounds = KW'(k); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    if (n < 5 || n % 2 == 0) begin
      chk(done && cyc == 0, "R2", "immediate done", cyc, 0);
      chk(prime == (n == 2 || n == 3), "R2", "small/even verdict", prime, n == 2 || n == 3);
      chk(reqs == 0, "R2", "no power request", reqs, 0);
    end else begin
      keff  = (k == 0) ? 1 : k;
      exp_p = !failed && passed == keff;
      chk(prime == exp_p, "R8", "verdict vs rounds", prime, exp_p);
      chk(!pending, "R7", "run ended on a decided round", pending, 0);
      if (math && is_prime(n)) chk(prime == 1'b1, "R8", "true prime accepted", prime, 1);
      if (k == 0) chk(openings == 1 || (!prime && openings <= 1), "R9", "zero rounds means one",
                      openings, 1);
    end
    held = prime;
    @(negedge clk);
    chk(!done && prime == held, "R12", "done pulse / verdict hold", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !prime && !busy && !exp_go, "R1", "outputs in reset",
        {done, prime, busy, exp_go}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !prime && !busy && !exp_go, "R1", "outputs after reset",
        {done, prime, busy, exp_go}, 0);

    for (int i = 0; i < VN; i++) run(int'(VEC[i][W+KW-1:KW]), int'(VEC[i][KW-1:0]), 1'b1);

    // R7: square gives 1 -> composite
    ovr[0] = 5; ovr[1] = 1; ovr_n = 2; ovr_i = 0;
    run(13, 1, 1'b0);
    chk(prime == 0, "R7", "square to one", prime, 0);
    // R7: square gives N-1 -> round passes
    ovr[0] = 5; ovr[1] = 12; ovr_n = 2; ovr_i = 0;
    run(13, 1, 1'b0);
    chk(prime == 1, "R7", "square to N-1", prime, 1);
    // R5: openings of 1 and N-1 both pass
    ovr[0] = 1; ovr[1] = 16; ovr_n = 2; ovr_i = 0;
    run(17, 2, 1'b0);
    chk(prime == 1 && reqs == 2, "R5", "decisive openings", reqs, 2);
    // R6: limit of S-1 squarings (S=4)
    ovr[0] = 3; ovr[1] = 9; ovr[2] = 13; ovr[3] = 15; ovr_n = 4; ovr_i = 0;
    run(17, 1, 1'b0);
    chk(prime == 0 && reqs == 4, "R6", "squarings exhausted", reqs, 4);
    // R6: S=1 allows no squaring
    ovr[0] = 5; ovr_n = 1; ovr_i = 0;
    run(11, 1, 1'b0);
    chk(prime == 0 && reqs == 1, "R6", "no squaring when S=1", reqs, 1);
    // R8: pass then fail stops early
    ovr[0] = 12; ovr[1] = 5; ovr[2] = 1; ovr_n = 3; ovr_i = 0;
    run(13, 3, 1'b0);
    chk(prime == 0 && reqs == 3, "R8", "failure in second round", reqs, 3);
    ovr_n = 0; ovr_i = 0;

    // R10: start coinciding with a completion
    poke = 1'b1;
    run(97, 3, 1'b1);
    chk(exp_mod == 97, "R10", "modulus kept across ignored start", exp_mod, 97);
    chk(prime == 1, "R10", "verdict unaffected", prime, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule